// File: doc/BRIEF.md
# Instruction Cycle and Length Predictor

This block looks at one 16-bit two-operand-style instruction word and predicts, without executing it, how many 16-bit words the instruction occupies and how many clock cycles it needs. A pipeline checker or trace monitor presents the first word of each instruction together with a valid strobe. One clock later the block reports the predicted length, the predicted cycle count and a flag that shows whether the source operand came from a constant-generating register.

The cycle count starts at one cycle for fetching the instruction word. Penalties are then added for the source addressing mode, for an indexed destination, for writing a result back to memory and for writing the program counter. Sources taken from the constant-generating registers cost neither an extra word nor an extra cycle. Relative jumps have a fixed cost. Words of the single-operand group are reported at the base cost.

Field layout of the word: operation code in bits 15:12, source register in bits 11:8, destination mode bit in bit 7, byte/word bit in bit 6, source mode in bits 5:4 (00 register, 01 indexed, 10 indirect, 11 indirect with auto-increment), destination register in bits 3:0. Register 0 is the program counter.

Top module: `instr_timing_predictor`

## Requirements
- R1: Results appear in the cycle after the strobe. `resValid` is high for exactly the cycles whose previous cycle had `inValid` high.
- R2: A two-operand word (bits 15:14 not 00) with register source, destination mode 0 and a destination register other than 0 gives length 1, 1 cycle and constant flag 0.
- R3: Source mode 10, or source mode 11 with a source register other than 0, adds 1 cycle and no word. Source mode 11 with source register 0 (immediate) adds 1 cycle and 1 word.
- R4: Source mode 01 with any source register other than 3 (this includes registers 0 and 2) adds 2 cycles and 1 word.
- R5: A source in register 3 in any mode, or in register 2 in mode 10 or 11, adds no cycle and no word and sets the constant flag. In every other case the flag is 0.
- R6: Destination mode 1 adds 2 cycles and 1 word. It adds 1 more cycle for the write-back unless the operation code is 9 or 11 (compare and bit test).
- R7: Destination mode 0 with destination register 0 adds 1 cycle when the operation code writes its result (neither 9 nor 11).
- R8: A word whose bits 15:13 are 001 is a jump: length 1, 2 cycles, constant flag 0.
- R9: A word whose bits 15:13 are 000 is reported as length 1, 1 cycle, constant flag 0.
- R10: While `inValid` is low, the length, cycle and flag outputs hold their last values, whatever `instrWord` does.
- R11: During and right after reset, all outputs are 0.
- R12: Length always lies between 1 and 3, the cycle count between 1 and 6, and the cycle count is never smaller than the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe: instrWord holds a first instruction word |
| instrWord | input | 16 | Instruction word to classify |
| resValid | output | 1 | Result valid, one cycle after the strobe |
| resLen | output | 2 | Predicted length in words |
| resCycles | output | 3 | Predicted cycle count |
| resConst | output | 1 | Source operand came from a constant-generating register |

## Verification
The assertions check on every cycle that the result strobe follows the input strobe, that the outputs stay frozen while no strobe arrives, that at most one source-mode penalty is active at a time, and that length and cycle count stay within their ranges and keep their ordering. Only the bench scenarios can show that each addressing mode receives its exact penalty. These scenarios cover the immediate, absolute and symbolic sources, the constant exemption, the exemption of compare and bit test from write-back, the program-counter destination and the three-word memory-to-memory case.

// File: rtl/instr_timing_pkg.sv
package instr_timing_pkg;
  localparam int unsigned WordW = 16;
  localparam int unsigned RegW  = 4;
  localparam int unsigned LenW  = 2;
  localparam int unsigned CycW  = 3;
  localparam int unsigned MaxLen = 3;
  localparam int unsigned MaxCyc = 6;

  localparam logic [RegW-1:0] PcReg    = 4'd0;
  localparam logic [RegW-1:0] ConstRegA = 4'd2;
  localparam logic [RegW-1:0] ConstRegB = 4'd3;
  localparam logic [3:0] OpCompare = 4'h9;
  localparam logic [3:0] OpBitTest = 4'hB;

  typedef enum logic [1:0] {
    SRC_REG  = 2'b00,
    SRC_IDX  = 2'b01,
    SRC_IND  = 2'b10,
    SRC_AINC = 2'b11
  } src_mode_e;

  // Penalty strobes from decode control to the summing datapath
  typedef struct packed {
    logic isJump;
    logic srcIdx;
    logic srcInd;
    logic srcImm;
    logic srcConst;
    logic dstIdx;
    logic dstWrite;
    logic pcWrite;
  } timing_ctl_t;
endpackage

// File: rtl/itc_decode.sv
module itc_decode
  import instr_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WordW-1:0] instrWord,
  output timing_ctl_t      ctl
);
  logic [3:0]      opCode;
  logic [RegW-1:0] srcReg;
  logic [RegW-1:0] dstReg;
  logic            dstMode;
  src_mode_e       srcMode;
  logic            twoOp;
  logic            writesResult;
  logic            constSrc;

  assign opCode  = instrWord[15:12];
  assign srcReg  = instrWord[11:8];
  assign dstMode = instrWord[7];
  assign srcMode = src_mode_e'(instrWord[5:4]);
  assign dstReg  = instrWord[3:0];

  always_comb begin
    twoOp        = (instrWord[15:14] != 2'b00);
    writesResult = (opCode != OpCompare) && (opCode != OpBitTest);
    constSrc     = twoOp && ((srcReg == ConstRegB) ||
                   ((srcReg == ConstRegA) && (srcMode inside {SRC_IND, SRC_AINC})));

    ctl          = '0;
    ctl.isJump   = (instrWord[15:13] == 3'b001);
    ctl.srcConst = constSrc;
    if (twoOp && !constSrc) begin
      ctl.srcIdx = (srcMode == SRC_IDX);
      ctl.srcImm = (srcMode == SRC_AINC) && (srcReg == PcReg);
      ctl.srcInd = (srcMode == SRC_IND) ||
                   ((srcMode == SRC_AINC) && (srcReg != PcReg));
    end
    if (twoOp) begin
      ctl.dstIdx   = dstMode;
      ctl.dstWrite = dstMode && writesResult;
      ctl.pcWrite  = !dstMode && (dstReg == PcReg) && writesResult;
    end
  end

  // R5: a constant source excludes every other source penalty
  assert_src_modes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    inValid |-> $onehot0({ctl.srcIdx, ctl.srcInd, ctl.srcImm, ctl.srcConst}));

  // R8: a jump word never raises an operand penalty
  assert_jump_no_operands_R8: assert property (@(posedge clk) disable iff (rst)
    (inValid && ctl.isJump) |-> !(ctl.srcIdx || ctl.dstIdx || ctl.pcWrite || ctl.srcConst));
endmodule

// File: rtl/itc_accum.sv
module itc_accum
  import instr_timing_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  timing_ctl_t     ctl,
  output logic            resValid,
  output logic [LenW-1:0] resLen,
  output logic [CycW-1:0] resCycles,
  output logic            resConst
);
  logic [LenW-1:0] lenSum;
  logic [CycW-1:0] cycSum;

  always_comb begin
    if (ctl.isJump) begin
      lenSum = LenW'(1);
      cycSum = CycW'(2);
    end else begin
      lenSum = LenW'(1) + LenW'(ctl.srcIdx) + LenW'(ctl.srcImm) + LenW'(ctl.dstIdx);
      cycSum = CycW'(1)
             + CycW'(ctl.srcInd | ctl.srcImm)
             + (ctl.srcIdx ? CycW'(2) : CycW'(0))
             + (ctl.dstIdx ? CycW'(2) : CycW'(0))
             + CycW'(ctl.dstWrite)
             + CycW'(ctl.pcWrite);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid  <= 1'b0;
      resLen    <= '0;
      resCycles <= '0;
      resConst  <= 1'b0;
    end else begin
      resValid <= inValid;
      if (inValid) begin
        resLen    <= lenSum;
        resCycles <= cycSum;
        resConst  <= ctl.srcConst && !ctl.isJump;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> resValid);
  assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !resValid);
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(resLen) && $stable(resCycles) && $stable(resConst)));
  assert_len_range_R12: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resLen >= LenW'(1) && resLen <= LenW'(MaxLen)));
  assert_cycle_range_R12: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resCycles >= CycW'(1) && resCycles <= CycW'(MaxCyc)));
  assert_cycles_cover_words_R12: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (CycW'(resLen) <= resCycles));
endmodule

// File: rtl/instr_timing_predictor.sv
module instr_timing_predictor
  import instr_timing_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WordW-1:0] instrWord,
  output logic             resValid,
  output logic [LenW-1:0]  resLen,
  output logic [CycW-1:0]  resCycles,
  output logic             resConst
);
  timing_ctl_t ctl;

  itc_decode i_decode (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .instrWord (instrWord),
    .ctl       (ctl)
  );

  itc_accum i_accum (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .ctl       (ctl),
    .resValid  (resValid),
    .resLen    (resLen),
    .resCycles (resCycles),
    .resConst  (resConst)
  );

  // R11: outputs are cleared in the cycle after reset
  assert_reset_clears_R11: assert property (@(posedge clk)
    $past(rst) |-> (!resValid && resLen == '0 && resCycles == '0 && !resConst));
endmodule

// File: tb/test_instr_timing_predictor.sv
`timescale 1ns/1ps
module test_instr_timing_predictor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] instrWord = 16'h0000;
  logic        resValid;
  logic [1:0]  resLen;
  logic [2:0]  resCycles;
  logic        resConst;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  instr_timing_predictor i_instr_timing_predictor (
    .clk(clk), .rst(rst), .inValid(inValid), .instrWord(instrWord),
    .resValid(resValid), .resLen(resLen), .resCycles(resCycles), .resConst(resConst)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic expectRes(input string req, input int eLen, input int eCyc, input int eConst);
    check(req, "valid", resValid, 1);
    check(req, "length", resLen, eLen);
    check(req, "cycles", resCycles, eCyc);
    check(req, "const", resConst, eConst);
  endtask

  // Strobe one word; on return the registered result is visible
  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    instrWord = w;
    inValid   = 1'b1;
    @(negedge clk);
    inValid   = 1'b0;
  endtask

  task automatic runCase(input string req, input logic [15:0] w,
                         input int eLen, input int eCyc, input int eConst);
    issue(w);
    expectRes(req, eLen, eCyc, eConst);
  endtask

  task automatic testReset();
    check("R11", "valid", resValid, 0);
    check("R11", "length", resLen, 0);
    check("R11", "cycles", resCycles, 0);
    check("R11", "const", resConst, 0);
  endtask

  task automatic testRegister();
    runCase("R2", 16'h540A, 1, 1, 0);
    runCase("R2", 16'h4F05, 1, 1, 0);
  endtask

  task automatic testIndirect();
    runCase("R3", 16'h542A, 1, 2, 0);   // indirect
    runCase("R3", 16'h543A, 1, 2, 0);   // auto-increment
    runCase("R3", 16'h503A, 2, 2, 0);   // immediate
  endtask

  task automatic testIndexed();
    runCase("R4", 16'h541A, 2, 3, 0);   // indexed
    runCase("R4", 16'h501A, 2, 3, 0);   // program-counter relative
    runCase("R4", 16'h521A, 2, 3, 0);   // absolute via register 2
  endtask

  task automatic testConstants();
    runCase("R5", 16'h531A, 1, 1, 1);   // register 3, mode 01
    runCase("R5", 16'h533A, 1, 1, 1);   // register 3, mode 11
    runCase("R5", 16'h522A, 1, 1, 1);   // register 2, mode 10
    runCase("R5", 16'h520A, 1, 1, 0);   // register 2, register mode
    runCase("R5", 16'h43A4, 2, 4, 1);   // constant into indexed destination
  endtask

  task automatic testDestination();
    runCase("R6", 16'h5090, 3, 6, 0);   // memory to memory
    runCase("R6", 16'h9094, 3, 5, 0);   // compare: no write-back
    runCase("R6", 16'hB4A4, 2, 4, 0);   // bit test, indirect source
    runCase("R7", 16'h4400, 1, 2, 0);   // move into program counter
    runCase("R7", 16'h9400, 1, 1, 0);   // compare with program counter
  endtask

  task automatic testJumpsAndOthers();
    runCase("R8", 16'h3C05, 1, 2, 0);
    runCase("R8", 16'h2000, 1, 2, 0);
    runCase("R8", 16'h3FFF, 1, 2, 0);
    runCase("R9", 16'h1284, 1, 1, 0);
    runCase("R9", 16'h0000, 1, 1, 0);
  endtask

  task automatic testHold();
    issue(16'h5090);
    expectRes("R10", 3, 6, 0);
    instrWord = 16'h531A;
    repeat (3) @(negedge clk);
    check("R10", "valid", resValid, 0);
    check("R10", "length", resLen, 3);
    check("R10", "cycles", resCycles, 6);
    check("R10", "const", resConst, 0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    instrWord = 16'h541A;
    inValid   = 1'b1;
    @(negedge clk);
    instrWord = 16'h531A;
    expectRes("R1", 2, 3, 0);
    @(negedge clk);
    inValid = 1'b0;
    expectRes("R1", 1, 1, 1);
    @(negedge clk);
    check("R1", "valid drop", resValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testRegister();
    testIndirect();
    testIndexed();
    testConstants();
    testDestination();
    testJumpsAndOthers();
    testHold();
    testBackToBack();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule